// File: doc/BRIEF.md
# SONET A1/A2 Frame Aligner

This block sits behind the serial-to-parallel stage of a SONET/SDH receiver. It takes one received bit per bit clock, searches every bit position of the incoming stream for the framing run of three A1 bytes followed by three A2 bytes, and moves its byte boundary so that the parallel output lines up with the frame. Each completed byte is presented on a byte bus with a one-clock strobe. A frame pulse marks the aligned third A2 byte.

The search is controlled from outside by a level-sensitive hunt request. The in-frame or out-of-frame decision is made elsewhere. While the request is high, every framing run found snaps the boundary and raises the pulse, frame after frame. While the request is low, the boundary keeps counting from its last position and no pulse is produced. The request must rise at least four byte periods before the A1/A2 transition for recovery to be guaranteed.

Top module: `frame_aligner`

## Requirements
- R1: A frame is detected when the most recent 48 received bits equal three A1 bytes (0xF6) followed by three A2 bytes (0x28), at any bit offset. Bits arrive most significant bit first. A run with only two A1 bytes is not detected.
- R2: Detection and realignment take place only while `hunt_req` is high. A framing run received while it is low moves neither the strobe timing nor the pulse.
- R3: While `hunt_req` stays high, every later framing run is detected and realigned again, including runs at a new bit offset.
- R4: On detection, in the clock after the last A2 bit enters, `byte_stb` is high and `byte_out` holds 0x28. Each later strobe comes 8 bit clocks after the previous one and carries the 8 bits received since then.
- R5: `frame_pulse` rises together with the strobe that carries the third A2 byte. It stays high for the whole byte period, 8 bit clocks, and falls with the next strobe.
- R6: `frame_pulse` is never high while `hunt_req` is low. It drops in the same cycle that the request falls.
- R7: With no realignment, `byte_stb` is a single-clock pulse every 8 bit clocks and the byte boundary stays where it was last placed.
- R8: After reset, `byte_out` is 0x00 and `byte_stb` and `frame_pulse` are low. The first strobe comes 8 bit clocks after reset is released and carries the first 8 bits received, the first bit landing in bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit is taken per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Received serial data bit |
| hunt_req | input | 1 | Level-sensitive out-of-frame request; enables search and realignment |
| byte_out | output | 8 | Aligned parallel byte, first received bit in bit 7 |
| byte_stb | output | 1 | One-clock strobe when a new byte is on `byte_out` |
| frame_pulse | output | 1 | High for one byte period with the aligned third A2 byte |

## Verification
A boundary register that is off by one or more bits shows up at the very next strobe as a byte whose bits are shifted against what was sent, so one byte period after the fault. A pattern comparator with a wrong constant or a wrong bit order either misses the framing run or matches at the wrong offset. The frame pulse then fails to appear, or appears with a byte other than 0x28, in the clock after the last A2 bit. A pulse latch that clears too early or too late shows as a pulse that is not exactly 8 bit clocks long. A pulse that ignores the request level shows the moment the request falls.

// File: rtl/fa_pkg.sv
package fa_pkg;

  // Width of the search window for a framing run of n1 + n2 bytes.
  function automatic int unsigned win_len(input int unsigned bw,
                                          input int unsigned n1,
                                          input int unsigned n2);
    return bw * (n1 + n2);
  endfunction

  // True when a phase count sits on the last bit slot of a byte.
  function automatic logic last_slot(input int unsigned ph,
                                     input int unsigned bw);
    return ph == bw - 1;
  endfunction

endpackage

// File: rtl/fa_window.sv
module fa_window #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned A1_CNT = 3,
  parameter int unsigned A2_CNT = 3,
  parameter logic [BYTE_W-1:0] A1_VAL = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              pat_hit
);
  localparam int unsigned WIN = fa_pkg::win_len(BYTE_W, A1_CNT, A2_CNT);
  localparam int unsigned NB  = A1_CNT + A2_CNT;

  logic [WIN-2:0] hist;
  logic [WIN-1:0] look;
  logic [WIN-1:0] pat;

  // Build the expected run: A1 bytes first (oldest), then A2 bytes.
  for (genvar k = 0; k < NB; k++) begin : g_pat
    if (k < A1_CNT) begin : g_a1
      assign pat[WIN-1-k*BYTE_W -: BYTE_W] = A1_VAL;
    end else begin : g_a2
      assign pat[WIN-1-k*BYTE_W -: BYTE_W] = A2_VAL;
    end
  end

  // Window including the bit arriving on this edge.
  assign look     = {hist, ser_bit};
  assign pat_hit  = (look == pat);
  assign cur_byte = look[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= look[WIN-2:0];
  end

endmodule

// File: rtl/fa_phase.sv
module fa_phase #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PW = $clog2(BYTE_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          realign,
  output logic          byte_take,
  output logic [PW-1:0] phase
);
  assign byte_take = realign || fa_pkg::last_slot(32'(phase), BYTE_W);

  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (byte_take) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  // A take without a realign only happens on the last slot of a byte.
  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (byte_take && !realign) |=> (phase == '0)); // R7

endmodule

// File: rtl/fa_pulse.sv
module fa_pulse #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_take,
  input  logic              realign,
  input  logic [BYTE_W-1:0] cur_byte,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              fp_hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out <= '0;
      byte_stb <= 1'b0;
      fp_hold  <= 1'b0;
    end else begin
      byte_stb <= byte_take;
      if (byte_take) begin
        byte_out <= cur_byte;
        fp_hold  <= realign;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb); // R7

  AST_PULSE_ENDS_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    $fell(fp_hold) |-> byte_stb); // R5

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned A1_CNT = 3,
  parameter int unsigned A2_CNT = 3,
  parameter logic [BYTE_W-1:0] A1_VAL = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              hunt_req,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_pulse
);
  localparam int unsigned PW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] cur_byte;
  logic              pat_hit;
  logic              realign;
  logic              byte_take;
  logic [PW-1:0]     phase;
  logic              fp_hold;

  fa_window #(
    .BYTE_W(BYTE_W), .A1_CNT(A1_CNT), .A2_CNT(A2_CNT),
    .A1_VAL(A1_VAL), .A2_VAL(A2_VAL)
  ) u_win (
    .clk(clk), .rst(rst), .ser_bit(ser_bit),
    .cur_byte(cur_byte), .pat_hit(pat_hit)
  );

  // Search result only counts while the request level is high.
  assign realign = pat_hit && hunt_req;

  fa_phase #(.BYTE_W(BYTE_W)) u_phase (
    .clk(clk), .rst(rst), .realign(realign),
    .byte_take(byte_take), .phase(phase)
  );

  fa_pulse #(.BYTE_W(BYTE_W)) u_pulse (
    .clk(clk), .rst(rst), .byte_take(byte_take), .realign(realign),
    .cur_byte(cur_byte), .byte_out(byte_out), .byte_stb(byte_stb),
    .fp_hold(fp_hold)
  );

  assign frame_pulse = fp_hold && hunt_req;

  AST_REALIGN_LOADS_A2: assert property (@(posedge clk) disable iff (rst)
    realign |=> (byte_stb && byte_out == A2_VAL && phase == '0)); // R4

  AST_PULSE_CARRIES_A2: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> (byte_out == A2_VAL)); // R5

  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(fp_hold) |-> $past(hunt_req)); // R2

endmodule

// File: tb/frame_aligner_tb.sv
`timescale 1ns/1ps
module frame_aligner_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_bit = 1'b0;
  logic       hunt_req = 1'b0;
  logic [7:0] byte_out;
  logic       byte_stb;
  logic       frame_pulse;

  int total = 0;
  int fails = 0;
  int fp_cnt = 0;
  bit done = 1'b0;

  localparam logic [7:0] A1 = 8'hF6;
  localparam logic [7:0] A2 = 8'h28;

  always #10 clk = ~clk;

  frame_aligner u_dut (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .hunt_req(hunt_req),
    .byte_out(byte_out), .byte_stb(byte_stb), .frame_pulse(frame_pulse)
  );

  always @(negedge clk) if (frame_pulse) fp_cnt <= fp_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives n bits MSB first; returns 2 ns after the edge that took the last bit.
  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_bit = v[i];
      @(posedge clk);
      #2;
    end
  endtask

  task automatic send_frame();
    for (int i = 0; i < 3; i++) send_bits(A1, 8);
    for (int i = 0; i < 3; i++) send_bits(A2, 8);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #2;
    chk("R8 byte_out at reset", byte_out, 0);
    chk("R8 byte_stb at reset", byte_stb, 0);
    chk("R8 frame_pulse at reset", frame_pulse, 0);
    rst = 1'b0;
    send_bits(8'h12, 8);
    chk("R8 first strobe", byte_stb, 1);
    chk("R8 first byte", byte_out, 8'h12);
  endtask

  task automatic t_idle_frame();
    int f0 = fp_cnt;
    send_bits(3'b101, 3);
    send_bits(5'b11110, 5);
    chk("R7 byte across offset", byte_out, 8'hBE);
    chk("R7 strobe on old boundary", byte_stb, 1);
    send_bits(3'b110, 3);
    send_bits(A1, 8); send_bits(A1, 8);
    for (int i = 0; i < 3; i++) send_bits(A2, 8);
    send_bits(5'b00000, 5);
    chk("R7 last byte on old boundary", byte_out, 8'h00);
    chk("R6 no pulse while request low", fp_cnt, f0);
  endtask

  task automatic t_hunt();
    hunt_req = 1'b1;
    for (int i = 0; i < 4; i++) send_bits(8'h00, 8);
    send_bits(3'b011, 3);
    send_frame();
    chk("R1 detect at offset 3 strobe", byte_stb, 1);
    chk("R4 third A2 aligned", byte_out, A2);
    chk("R5 pulse with third A2", frame_pulse, 1);
    send_bits(7'b0011110, 7);
    chk("R5 pulse held mid byte", frame_pulse, 1);
    chk("R5 no strobe mid byte", byte_stb, 0);
    send_bits(1'b0, 1);
    chk("R4 next byte after 8 bits", byte_out, 8'h3C);
    chk("R5 pulse ends at next byte", frame_pulse, 0);
    send_bits(8'h5A, 8);
    chk("R4 realigned byte stream", byte_out, 8'h5A);
  endtask

  task automatic t_partial();
    int f0 = fp_cnt;
    send_bits(2'b10, 2);
    send_bits(A1, 8); send_bits(A1, 8);
    for (int i = 0; i < 3; i++) send_bits(A2, 8);
    send_bits(8'h00, 8);
    chk("R1 two A1 bytes not a frame", fp_cnt, f0);
  endtask

  task automatic t_repeat();
    send_bits(5'b10101, 5);
    send_frame();
    chk("R3 second frame detected", frame_pulse, 1);
    chk("R3 second frame aligned", byte_out, A2);
    chk("R3 second frame strobe", byte_stb, 1);
    hunt_req = 1'b0;
    #1;
    chk("R6 pulse drops with request", frame_pulse, 0);
  endtask

  task automatic t_hold();
    int f0 = fp_cnt;
    send_bits(5'b10110, 5);
    send_frame();
    chk("R2 no realign while request low", byte_stb, 0);
    send_bits(3'b111, 3);
    chk("R7 boundary held strobe", byte_stb, 1);
    chk("R7 boundary held byte", byte_out, 8'h47);
    chk("R2 no pulse while request low", fp_cnt, f0);
  endtask

  initial begin
    t_reset();
    t_idle_frame();
    t_hunt();
    t_partial();
    t_repeat();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule